// File: doc/BRIEF.md
# Signed Multiply-Accumulate Register Unit

This unit sits beside a small processor core and keeps a 42-bit signed running sum. Each accumulate command multiplies two signed 16-bit operands and adds the full product to the sum. The sum is held as a 10-bit upper part and a 32-bit lower part. The core can clear it, load either part from a 32-bit bus, and read either part back.

A read also reports zero, negative and overflow status. The zero and negative status describe the whole 42-bit sum, not only the part being read. The core presents its current condition flags on `flags_in`. One cycle after each command, the unit returns the updated flags on `flags_out`, so the core can copy them back into its own condition register.

Top module: `mac_accum`

## Requirements
- R1: After a synchronous reset the sum is zero, `rd_valid` is low and `flags_out` is 0000.
- R2: A clear command sets both parts to zero. Clear takes priority over a load or an accumulate issued in the same cycle.
- R3: An accumulate adds the signed 16x16 product, sign-extended to 42 bits, into the sum. The sum wraps modulo 2^42 with no saturation, so 2^41-1 plus 1 gives -2^41.
- R4: Carries out of bit 31 enter the upper part. Eight accumulates of 0x7FFF times 0x7FFF from zero give a lower part of 0xFFF80008 and an upper part of 1.
- R5: A load with `ld_hi`=0 stores all 32 bus bits into the lower part. A load with `ld_hi`=1 stores only bus bits [9:0] into the upper part, so 0xA5A5A5A5 reads back as 0x000001A5.
- R6: When a load and an accumulate are issued in the same cycle, the load is applied and the accumulate is dropped.
- R7: A read with `rd_hi`=0 returns the lower part. A read with `rd_hi`=1 returns the upper part sign-extended to 32 bits. Data and `rd_valid` appear on the next cycle and show the sum as it was before any command issued in the same cycle.
- R8: The flags are packed as [3]=Z, [2]=N, [1]=V, [0]=C. After a read, Z is 1 only when all 42 bits of the sum are zero, whichever part was read.
- R9: After a read, N equals bit 41 of the sum and V is 0. C passes through from `flags_in`.
- R10: After a load, V and C are 0, and Z and N pass through from `flags_in`.
- R11: When there is no read and no load (a clear, an accumulate, or no command), `flags_out` equals the previous cycle's `flags_in`, so these commands never set a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_en | input | 1 | Clear command |
| ld_en | input | 1 | Load command |
| ld_hi | input | 1 | Load target: 0 lower part, 1 upper part |
| ld_data | input | 32 | Load data bus |
| mac_en | input | 1 | Accumulate command |
| op_a | input | 16 | Signed operand A |
| op_b | input | 16 | Signed operand B |
| rd_en | input | 1 | Read command |
| rd_hi | input | 1 | Read target: 0 lower part, 1 upper part |
| flags_in | input | 4 | Current condition flags {Z,N,V,C} |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| flags_out | output | 4 | Updated condition flags {Z,N,V,C} |

## Verification
The assertions check on every cycle how the flags respond to each command. After a load, V and C are cleared. After a read, V is cleared, N matches the sign of upper-part data, and Z agrees with the returned data. Without a read or a load, the flags pass through unchanged. The assertions also check that upper-part reads are sign-extended and that `rd_valid` follows the read command. The values the sum actually takes can only be shown by the bench's scenarios and its behavioural model. These include carry into the upper part, wrap at 2^42, the priority among clear, load and accumulate, and the value a read returns when a command is issued in the same cycle.

// File: rtl/mac_accum.sv
module mac_accum #(
  parameter int OPW = 16,
  parameter int LOW = 32,
  parameter int HIW = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr_en,
  input  logic           ld_en,
  input  logic           ld_hi,
  input  logic [LOW-1:0] ld_data,
  input  logic           mac_en,
  input  logic [OPW-1:0] op_a,
  input  logic [OPW-1:0] op_b,
  input  logic           rd_en,
  input  logic           rd_hi,
  input  logic [3:0]     flags_in,
  output logic [LOW-1:0] rd_data,
  output logic           rd_valid,
  output logic [3:0]     flags_out
);
  localparam int ACCW = LOW + HIW;
  localparam int PW   = 2 * OPW;

  logic signed [PW-1:0] prod;
  logic [ACCW-1:0] prod_x, acc, acc_nxt;
  logic [LOW-1:0]  rd_word;
  logic [3:0]      fl_nxt;

  assign prod    = $signed(op_a) * $signed(op_b);
  assign prod_x  = {{(ACCW-PW){prod[PW-1]}}, prod};
  assign rd_word = rd_hi ? {{(LOW-HIW){acc[ACCW-1]}}, acc[ACCW-1:LOW]} : acc[LOW-1:0];

  always_comb begin
    acc_nxt = acc;
    if (clr_en)
      acc_nxt = '0;
    else if (ld_en) begin
      if (ld_hi) acc_nxt[ACCW-1:LOW] = ld_data[HIW-1:0];
      else       acc_nxt[LOW-1:0]    = ld_data;
    end else if (mac_en)
      acc_nxt = acc + prod_x;
  end

  always_comb begin
    fl_nxt = flags_in;
    if (rd_en) begin
      fl_nxt[3] = (acc == '0);
      fl_nxt[2] = acc[ACCW-1];
      fl_nxt[1] = 1'b0;
    end
    if (ld_en) fl_nxt[1:0] = 2'b00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
      flags_out <= 4'b0000;
    end else begin
      acc       <= acc_nxt;
      rd_valid  <= rd_en;
      flags_out <= fl_nxt;
      if (rd_en) rd_data <= rd_word;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (!rd_valid && flags_out == 4'b0000));
  // R7
  rd_valid_chk: assert property (@(posedge clk) disable iff (rst) rd_en |=> rd_valid);
  // R7
  hi_sext_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(rd_hi)) |-> (rd_data[LOW-1:HIW] == {(LOW-HIW){rd_data[HIW-1]}}));
  // R8
  zero_data_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && flags_out[3]) |-> (rd_data == '0));
  // R9
  read_ovf_chk: assert property (@(posedge clk) disable iff (rst) rd_en |=> !flags_out[1]);
  // R9
  hi_neg_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(rd_hi)) |-> (flags_out[2] == rd_data[LOW-1]));
  // R10
  load_vc_chk: assert property (@(posedge clk) disable iff (rst) ld_en |=> (flags_out[1:0] == 2'b00));
  // R11
  pass_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !ld_en) |=> (flags_out == $past(flags_in)));
endmodule

// File: tb/mac_accum_test.sv
module mac_accum_test;
  logic clk = 1'b0, rst = 1'b1;
  logic clr_en = 0, ld_en = 0, ld_hi = 0, mac_en = 0, rd_en = 0, rd_hi = 0;
  logic [31:0] ld_data = '0;
  logic [15:0] op_a = '0, op_b = '0;
  logic [3:0]  flags_in = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [3:0]  flags_out;

  int tests = 0, fails = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  mac_accum uut (.clk(clk), .rst(rst), .clr_en(clr_en), .ld_en(ld_en), .ld_hi(ld_hi),
    .ld_data(ld_data), .mac_en(mac_en), .op_a(op_a), .op_b(op_b), .rd_en(rd_en),
    .rd_hi(rd_hi), .flags_in(flags_in), .rd_data(rd_data), .rd_valid(rd_valid),
    .flags_out(flags_out));

  longint      macc = 0;
  logic [31:0] e_data = '0;
  logic        e_valid = 1'b0;
  logic [3:0]  e_flags = '0;

  function automatic longint wrap42(longint v);
    logic signed [41:0] t;
    t = v[41:0];
    return longint'(t);
  endfunction

  always @(posedge clk) begin
    longint hi;
    logic [41:0] raw;
    if (rst) begin
      macc = 0; e_valid = 0; e_flags = 0;
    end else begin
      hi = macc >>> 32;
      e_valid = rd_en;
      if (rd_en) e_data = rd_hi ? hi[31:0] : macc[31:0];
      e_flags = flags_in;
      if (rd_en) begin
        e_flags[3] = (macc == 0);
        e_flags[2] = (macc < 0);
        e_flags[1] = 1'b0;
      end
      if (ld_en) e_flags[1:0] = 2'b00;
      raw = macc[41:0];
      if (clr_en) macc = 0;
      else if (ld_en) begin
        if (ld_hi) raw[41:32] = ld_data[9:0];
        else       raw[31:0]  = ld_data;
        macc = wrap42(longint'(raw));
      end else if (mac_en)
        macc = wrap42(macc + longint'($signed(op_a)) * longint'($signed(op_b)));
    end
  end

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check({31'd0, rd_valid}, {31'd0, e_valid}, {cur_req, " rd_valid"});
      check({28'd0, flags_out}, {28'd0, e_flags}, {cur_req, " flags"});
      if (e_valid) check(rd_data, e_data, {cur_req, " rd_data"});
    end
  end

  task automatic idle();
    clr_en = 0; ld_en = 0; mac_en = 0; rd_en = 0;
  endtask

  task automatic cyc();
    @(negedge clk);
    idle();
  endtask

  task automatic do_clr();
    cyc(); clr_en = 1;
  endtask

  task automatic do_ld(logic hi, logic [31:0] d);
    cyc(); ld_en = 1; ld_hi = hi; ld_data = d;
  endtask

  task automatic do_mac(logic [15:0] a, logic [15:0] b);
    cyc(); mac_en = 1; op_a = a; op_b = b;
  endtask

  task automatic read_chk(logic hi, logic [31:0] exp, logic [3:0] expf, string tag);
    cyc(); rd_en = 1; rd_hi = hi;
    cyc();
    check(rd_data, exp, {tag, " data"});
    check({28'd0, flags_out}, {28'd0, expf}, {tag, " flags"});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check({31'd0, rd_valid}, 32'd0, "R1 rd_valid after reset");
    check({28'd0, flags_out}, 32'd0, "R1 flags after reset");

    cur_req = "R5";
    flags_in = 4'b1111;
    do_ld(0, 32'hA5A5A5A5);
    cyc();
    check({28'd0, flags_out}, 32'hC, "R10 load clears V C keeps Z N");
    flags_in = 4'b0000;
    read_chk(0, 32'hA5A5A5A5, 4'b0000, "R5 low load");
    do_ld(1, 32'hA5A5A5A5);
    read_chk(1, 32'h000001A5, 4'b0000, "R5 high load keeps 10 bits");
    do_ld(1, 32'h00000200);
    read_chk(1, 32'hFFFFFE00, 4'b0100, "R7 high sign extension");

    cur_req = "R2";
    do_clr();
    read_chk(0, 32'h0, 4'b1000, "R2 clear low");
    read_chk(1, 32'h0, 4'b1000, "R8 zero on whole sum");

    cur_req = "R8";
    do_mac(16'd2, 16'd2);
    read_chk(0, 32'd4, 4'b0000, "R3 2x2 low");
    read_chk(1, 32'd0, 4'b0000, "R8 high reads 0 but Z clear");

    cur_req = "R9";
    do_clr();
    do_mac(16'hFFFE, 16'd2);
    read_chk(0, 32'hFFFFFFFC, 4'b0100, "R3 -2x2 low");
    read_chk(1, 32'hFFFFFFFF, 4'b0100, "R9 -2x2 high negative");

    cur_req = "R4";
    do_clr();
    for (int i = 0; i < 8; i++) do_mac(16'h7FFF, 16'h7FFF);
    read_chk(0, 32'hFFF80008, 4'b0000, "R4 carry low");
    read_chk(1, 32'h00000001, 4'b0000, "R4 carry high");

    cur_req = "R6";
    do_clr();
    cyc(); ld_en = 1; ld_hi = 0; ld_data = 32'd5; mac_en = 1; op_a = 16'd3; op_b = 16'd3;
    read_chk(0, 32'd5, 4'b0000, "R6 load beats accumulate");
    cyc(); clr_en = 1; ld_en = 1; ld_hi = 0; ld_data = 32'd7; mac_en = 1;
    read_chk(0, 32'd0, 4'b1000, "R2 clear beats load");

    cur_req = "R7";
    do_clr();
    cyc(); mac_en = 1; op_a = 16'd2; op_b = 16'd2; rd_en = 1; rd_hi = 0;
    cyc();
    check(rd_data, 32'd0, "R7 read sees value before same-cycle accumulate");
    read_chk(0, 32'd4, 4'b0000, "R7 accumulate then applied");

    cur_req = "R11";
    flags_in = 4'b1111;
    do_mac(16'd1, 16'd1);
    cyc();
    check({28'd0, flags_out}, 32'hF, "R11 accumulate passes flags");
    do_clr();
    cyc();
    check({28'd0, flags_out}, 32'hF, "R11 clear passes flags");
    flags_in = 4'b0011;
    read_chk(0, 32'd0, 4'b1001, "R9 read clears V keeps C");
    flags_in = 4'b0000;

    cur_req = "R3";
    do_ld(1, 32'h1FF);
    do_ld(0, 32'hFFFFFFFF);
    do_mac(16'd1, 16'd1);
    read_chk(1, 32'hFFFFFE00, 4'b0100, "R3 wrap at 2^42 high");
    read_chk(0, 32'h0, 4'b0100, "R3 wrap at 2^42 low");

    cur_req = "R3";
    for (int i = 0; i < 3000; i++) begin
      cyc();
      clr_en   = ($urandom % 16) == 0;
      ld_en    = ($urandom % 6) == 0;
      ld_hi    = $urandom % 2;
      ld_data  = $urandom;
      mac_en   = ($urandom % 3) != 0;
      op_a     = $urandom;
      op_b     = $urandom;
      rd_en    = ($urandom % 2) == 0;
      rd_hi    = $urandom % 2;
      flags_in = $urandom;
    end
    cyc();
    cyc();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule